// File: doc/BRIEF.md
# Rotating Word Serializer with Lane Select

The block accepts 32-bit words over a ready/valid input and plays each one out through a 32-bit register. The register rotates right on every active cycle. Software-style configuration inputs set the rotate distance per cycle and the number of rotations a word receives before the next word replaces it. Because the register rotates rather than shifts, a left shift is obtained by programming the word width minus the wanted distance. When the rotate distance times the rotation count exceeds the word width, bits come round again and appear on the output more than once.

Eight output lanes each carry one bit. Each lane has its own 5-bit index that picks a register bit. When the coupled flag is set, the indices at the top of the range pick bits of an external 8-bit parallel bus instead. Lane outputs are registered and change only on cycles where the register rotates. A shift-active strobe marks those cycles so that a neighbouring clock generator can advance in step. An enable input gates all activity: while it is low, no word is taken and the rotation count starts over.

Top module: `rot_serializer`

## Requirements
- R1: After reset, `lane_out` is 0 and `shift_active` is 0, and `in_ready` equals `enable`, because the register starts empty.
- R2: While `enable` is high and the register is empty, `in_ready` is 1. A cycle with `in_valid` and `in_ready` both high loads `in_data` into the register at the next edge.
- R3: On each cycle with `shift_active` high, the register rotates right by `shift_amt` (0 to 31): bit i becomes old bit (i+shift_amt) mod 32. A value of 32-k gives a left shift by k.
- R4: A word is rotated `shift_cnt` times (0 encodes 32) and then replaced. `in_ready` is high during the last rotation, so a word offered then loads with no idle cycle in between.
- R5: The rotation count is counted in operations and not in bit distance. When shift_amt times the count exceeds 32, register bits reach the lanes more than once.
- R6: If no word is offered when a refill is due, the register empties. It then holds its value with `shift_active` low and `in_ready` high, and loads on the first cycle that `in_valid` is seen.
- R7: While `enable` is low, no word is taken, the register does not rotate, and `lane_out` holds. The rotation count restarts from zero, and a word already held is rotated a full count again after `enable` returns.
- R8: On each shift cycle, lane i (index `lane_sel[5*i+4:5*i]`) registers the register bit at that index, as it stood before that cycle's rotation. On other cycles the lane holds its value.
- R9: With `coupled` set, a lane index from 24 to 31 takes `ext_bus[index-24]`, sampled in the shift cycle. Indices 0 to 23 still pick register bits.
- R10: With `coupled` clear, lane indices 24 to 31 pick register bits 24 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Allows taking words and rotating |
| coupled | input | 1 | Maps the top 8 lane indices to ext_bus |
| shift_amt | input | 5 | Right-rotate distance per shift cycle |
| shift_cnt | input | 5 | Rotations per word, 0 means 32 |
| lane_sel | input | 40 | Eight 5-bit lane indices, lane i at bits 5*i+4:5*i |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block takes the offered word this cycle |
| in_data | input | 32 | Input word |
| ext_bus | input | 8 | External parallel bits for coupled mode |
| shift_active | output | 1 | High on cycles where the register rotates |
| lane_out | output | 8 | Registered lane bits |

## Verification
The bench uses the default parameters: a 32-bit register, 8 lanes and an 8-bit external bus. With these values every lane index, the boundary between index 23 and index 24 in both coupled settings, and the count encoding where 0 stands for 32 can all be reached. Rotate distances of 1, 12 and 28 cover plain streaming, repetition and emulated left shifts. Input stalls and enable drops are placed in the middle of words, so the empty-register hold and the restart of the count are both exercised against the cycle model.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned RS_WORD_W = 32;
  localparam int unsigned RS_LANES  = 8;
  localparam int unsigned RS_EXT_W  = 8;

  // a programmed count of zero stands for one full word of rotations
  function automatic int unsigned rs_span(input int unsigned cfg, input int unsigned word_w);
    return (cfg == 0) ? word_w : cfg;
  endfunction
endpackage

// File: rtl/rs_rotate.sv
module rs_rotate #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned AMT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  output logic [WORD_W-1:0] dout
);
  logic [2*WORD_W-1:0] doubled;

  always_comb begin
    doubled = {din, din};
    dout    = doubled[amt +: WORD_W];
  end
endmodule

// File: rtl/rs_shift_count.sv
module rs_shift_count
  import rs_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CFG_W = $clog2(WORD_W),
  localparam int unsigned CNT_W = CFG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             shift,
  input  logic [CFG_W-1:0] cfg,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d, span;

  always_comb begin
    span = CNT_W'(rs_span(int'(cfg), WORD_W));
    last = (cnt_q == span - CNT_W'(1));
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!enable)    cnt_d = '0;
    else if (shift) cnt_d = last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: a low enable restarts the rotation count
  a_r7_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0));

  // R4: a rotation that is not the last advances the count by one
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && shift && !last) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/rs_lane_sel.sv
module rs_lane_sel #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LANES  = 8,
  parameter int unsigned EXT_W  = 8,
  localparam int unsigned SEL_W    = $clog2(WORD_W),
  localparam int unsigned EXT_IW   = $clog2(EXT_W),
  localparam int unsigned EXT_BASE = WORD_W - EXT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift,
  input  logic                   coupled,
  input  logic [WORD_W-1:0]      word,
  input  logic [EXT_W-1:0]       ext_bus,
  input  logic [LANES*SEL_W-1:0] sel,
  output logic [LANES-1:0]       lane_q
);
  logic [LANES-1:0] lane_d;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SEL_W-1:0] idx;
    logic [SEL_W-1:0] ext_off;
    logic             pick;

    always_comb begin
      idx     = sel[i*SEL_W +: SEL_W];
      ext_off = idx - SEL_W'(EXT_BASE);
      if (coupled && (idx >= SEL_W'(EXT_BASE))) pick = ext_bus[ext_off[EXT_IW-1:0]];
      else                                      pick = word[idx];
      lane_d[i] = shift ? pick : lane_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= '0;
    else        lane_q <= lane_d;
  end

  // R8: lanes change only on shift cycles
  a_r8_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(lane_q));
endmodule

// File: rtl/rot_serializer.sv
module rot_serializer
  import rs_pkg::*;
#(
  parameter int unsigned WORD_W = RS_WORD_W,
  parameter int unsigned LANES  = RS_LANES,
  parameter int unsigned EXT_W  = RS_EXT_W,
  localparam int unsigned SEL_W = $clog2(WORD_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   coupled,
  input  logic [SEL_W-1:0]       shift_amt,
  input  logic [SEL_W-1:0]       shift_cnt,
  input  logic [LANES*SEL_W-1:0] lane_sel,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [WORD_W-1:0]      in_data,
  input  logic [EXT_W-1:0]       ext_bus,
  output logic                   shift_active,
  output logic [LANES-1:0]       lane_out
);
  // reset: asserted at once, released after two clock edges
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic [WORD_W-1:0] word_q, word_d, rotated;
  logic              full_q, full_d;
  logic              last, take;

  always_comb begin
    shift_active = enable && full_q;
    in_ready     = enable && (!full_q || last);
    take         = in_valid && in_ready;
  end

  always_comb begin
    word_d = word_q;
    full_d = full_q;
    if (take) begin
      word_d = in_data;
      full_d = 1'b1;
    end else if (shift_active) begin
      word_d = rotated;
      if (last) full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      word_q <= '0;
      full_q <= 1'b0;
    end else begin
      word_q <= word_d;
      full_q <= full_d;
    end
  end

  rs_rotate #(.WORD_W(WORD_W)) u_rot (
    .din(word_q), .amt(shift_amt), .dout(rotated)
  );

  rs_shift_count #(.WORD_W(WORD_W)) u_cnt (
    .clk(clk), .rst_n(rst_s), .enable(enable), .shift(shift_active),
    .cfg(shift_cnt), .last(last)
  );

  rs_lane_sel #(.WORD_W(WORD_W), .LANES(LANES), .EXT_W(EXT_W)) u_lanes (
    .clk(clk), .rst_n(rst_s), .shift(shift_active), .coupled(coupled),
    .word(word_q), .ext_bus(ext_bus), .sel(lane_sel), .lane_q(lane_out)
  );

  // R2: an accepted word is what the register holds next
  a_r2_load_word: assert property (@(posedge clk) disable iff (!rst_s)
    (in_valid && in_ready) |=> (word_q == $past(in_data)));

  // R6: with no rotation and no load the register keeps its contents
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (!shift_active && !(in_valid && in_ready)) |=> $stable(word_q));

  // R4: a word offered during the last rotation keeps the register full
  a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_s)
    (shift_active && last && in_valid) |=> full_q);
endmodule

// File: tb/rot_serializer_test.sv
module rot_serializer_test;
  logic        clk = 1'b0;
  logic        rst_n, enable, coupled, in_valid;
  logic [4:0]  shift_amt, shift_cnt;
  logic [39:0] lane_sel;
  logic [31:0] in_data;
  logic [7:0]  ext_bus;
  logic        in_ready, shift_active;
  logic [7:0]  lane_out;

  always #10 clk = ~clk;

  rot_serializer uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .coupled(coupled),
    .shift_amt(shift_amt), .shift_cnt(shift_cnt), .lane_sel(lane_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .ext_bus(ext_bus), .shift_active(shift_active), .lane_out(lane_out)
  );

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R1";

  // behavioural reference state
  logic [31:0] m_reg;
  logic        m_full;
  int          m_cnt;
  logic [7:0]  m_lane;

  function automatic logic [31:0] word_of(input int k);
    return (32'h9E37_79B9 * (k + 1)) ^ (32'(k) << 7);
  endfunction

  function automatic logic [31:0] rotr(input logic [31:0] v, input int a);
    if (a == 0) return v;
    return (v >> a) | (v << (32 - a));
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int  span;
    bit  last, act, rdy;
    if (!rst_n) begin
      m_reg = '0; m_full = 1'b0; m_cnt = 0; m_lane = '0;
    end else begin
      span = (shift_cnt == 0) ? 32 : int'(shift_cnt);
      last = m_full && (m_cnt == span - 1);
      act  = enable && m_full;
      rdy  = enable && (!m_full || last);
      check("shift_active", 32'(shift_active), 32'(act));
      check("in_ready", 32'(in_ready), 32'(rdy));
      check("lane_out", 32'(lane_out), 32'(m_lane));
      if (act) begin
        for (int i = 0; i < 8; i++) begin
          int s;
          s = int'(lane_sel[i*5 +: 5]);
          m_lane[i] = (coupled && s >= 24) ? ext_bus[s-24] : m_reg[s];
        end
      end
      if (!enable) m_cnt = 0;
      else if (act) begin
        if (last) begin
          m_cnt = 0;
          if (in_valid) m_reg = in_data;
          else begin m_reg = rotr(m_reg, int'(shift_amt)); m_full = 1'b0; end
        end else begin
          m_cnt++;
          m_reg = rotr(m_reg, int'(shift_amt));
        end
      end else if (rdy && in_valid) begin
        m_reg = in_data; m_full = 1'b1; m_cnt = 0;
      end
    end
  end

  int idx = 0;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic reconfig(input int amt, input int n, input bit cpl, input string t);
    enable = 1'b0; in_valid = 1'b0;
    repeat (3) step();
    shift_amt = 5'(amt); shift_cnt = 5'(n); coupled = cpl; tag = t;
    enable = 1'b1;
  endtask

  // stall_mod: offer a word only every stall_mod-th cycle; dis_mod: drop enable periodically
  task automatic feed(input int cycles, input int stall_mod, input int dis_mod);
    for (int c = 0; c < cycles; c++) begin
      bit hs;
      @(negedge clk);
      hs = in_valid && in_ready;
      @(posedge clk); #1;
      if (hs) idx++;
      in_data  = word_of(idx);
      in_valid = (stall_mod == 0) || (c % stall_mod == 0);
      enable   = (dis_mod == 0) || (c % dis_mod != dis_mod - 1);
      ext_bus  = word_of(idx + c)[15:8];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; coupled = 1'b0; in_valid = 1'b0;
    shift_amt = 5'd1; shift_cnt = 5'd8; in_data = '0; ext_bus = '0;
    for (int i = 0; i < 8; i++) lane_sel[i*5 +: 5] = 5'(i);
    repeat (3) step();
    rst_n = 1'b1;
    // R1: reset state compared by the model while idle
    repeat (4) step();
    @(negedge clk);
    check("R1 lane_out after reset", 32'(lane_out), 32'h0);
    check("R1 shift_active after reset", 32'(shift_active), 32'h0);
    step();
    // R2 R3 R4: streaming, rotate by 1, eight rotations per word
    reconfig(1, 8, 1'b0, "R2/R3/R4 stream");
    feed(120, 0, 0);
    // R3: emulated left shift by 4, four rotations
    for (int i = 0; i < 8; i++) lane_sel[i*5 +: 5] = 5'((i * 5 + 3) % 32);
    reconfig(28, 4, 1'b0, "R3 left shift");
    feed(100, 0, 0);
    // R4 R5: count 0 means 32, rotate 12 repeats bits
    reconfig(12, 0, 1'b0, "R4/R5 count32 repeat");
    feed(200, 0, 0);
    // R6: sparse input, register runs empty between words
    reconfig(3, 5, 1'b0, "R6 starve");
    feed(150, 9, 0);
    // R7: enable drops in mid-word
    reconfig(5, 11, 1'b0, "R7 enable drop");
    feed(200, 0, 7);
    // R9: coupled, upper indices from ext_bus
    for (int i = 0; i < 8; i++) lane_sel[i*5 +: 5] = 5'((i < 4) ? 20 + i : 24 + 2 * (i - 4) + 1);
    reconfig(2, 6, 1'b1, "R9 coupled");
    feed(150, 0, 0);
    for (int i = 0; i < 8; i++) lane_sel[i*5 +: 5] = 5'(24 + i);
    reconfig(7, 9, 1'b1, "R9 coupled top");
    feed(150, 4, 0);
    // R10: same indices with coupled clear pick register bits
    reconfig(7, 9, 1'b0, "R10 uncoupled top");
    feed(150, 4, 0);
    // R8: lane hold while stalled and disabled
    reconfig(1, 3, 1'b0, "R8 lane hold");
    feed(120, 6, 5);
    enable = 1'b0; in_valid = 1'b0;
    repeat (5) step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule